// File: doc/BRIEF.md
# Warbling Ringer Square-Wave Generator

This block makes the square-wave control signal for a loudspeaker driver so that an incoming-call alert can sound while a voice call is already in progress. Two half-period divisors describe two tones. A warble timer switches the generator from one tone to the other at a programmed interval, which gives the familiar two-note ring.

A small write-only register port holds these settings: the two divisors, the warble interval, and a control word. The control word has a routing bit, an enable bit and a 2-bit attenuation code. The routing bit sends the square wave to the ringer path and away from the codec path. The enable bit starts the generator and also turns on the downstream gain stage. The attenuation code is passed straight to that gain stage.

Top module: `warble_ringer`

## Requirements
- R1: While reset is asserted, and after it is released with no writes, `ring_sq`, `path_ringer` and `gain_en` are 0 and `atten_code` is 00. All registers clear to 0.
- R2: A write is taken on a rising clock edge when `wr_en` is 1. The address map is:
  - address 0: tone A divisor, `wr_data[DIV_W-1:0]`
  - address 1: tone B divisor, `wr_data[DIV_W-1:0]`
  - address 2: warble interval, `wr_data[WARB_W-1:0]`
  - address 3: control word. Bit 0 routes to the ringer, bit 1 is the enable, bits 3:2 are the attenuation.
- R3: Let edge k be the edge that sets the enable. The square wave rises at edge k+1. Each high or low half then lasts D clocks, where D is the divisor of the selected tone. A divisor of 0 behaves as 1.
- R4: With warble interval W not 0, the tone selection flips between A and B every W clocks, counted from the first enabled edge. A reload on the edge of a flip still uses the earlier selection. With W = 0 the generator stays on tone A.
- R5: A divisor written while its tone is playing does not shorten or extend the current half-period. It is used at the next reload.
- R6: One clock after the enable reads 0, the square wave is low. The tone and warble counters clear. When the enable is set again, generation restarts on tone A with a rising edge, as in R3.
- R7: `ring_sq` is high only while the routing bit is 1. With the routing bit at 0 the generator keeps running but `ring_sq` stays low. `path_ringer` shows the routing bit.
- R8: `atten_code` shows control bits 3:2 unchanged: 00 = 0 dB (loudest), 01 = -8 dB, 10 = -16 dB, 11 = -24 dB. `gain_en` shows the enable bit.
- R9: Writes to addresses 4 to 7 have no effect on any output or on the generator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | DATA_W | Register write data |
| ring_sq | output | 1 | Gated square wave to the ringer driver |
| path_ringer | output | 1 | Routing bit: 1 = ringer path, 0 = codec path |
| gain_en | output | 1 | Enable for the ringer gain stage |
| atten_code | output | 2 | Ringer attenuation code |

## Verification
The hardest case to reach is a warble flip, a divisor rewrite and a reload that all fall on the same edge. From the ports it also has to line up with an enable toggle or a routing change. Directed sequences pin down the exact start-up timing and the disable/restart behaviour. After that, a long seeded random stream writes small divisors and short warble intervals at random addresses and random gaps. This makes the generator cross these collisions many times. A cycle-accurate reference in the bench is compared against every output on every clock.

// File: rtl/wr_pkg.sv
package wr_pkg;
    typedef enum logic [2:0] {
        ADDR_TONE_A = 3'd0,
        ADDR_TONE_B = 3'd1,
        ADDR_WARBLE = 3'd2,
        ADDR_CTRL   = 3'd3
    } wr_addr_e;

    // control word, bit 0 upward: routing, enable, attenuation
    typedef struct packed {
        logic [1:0] atten;
        logic       enable;
        logic       to_ringer;
    } wr_ctrl_t;

    localparam int CTRL_W = $bits(wr_ctrl_t);
endpackage

// File: rtl/wr_regs.sv
module wr_regs
    import wr_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DIV_W  = 12,
    parameter int WARB_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DIV_W-1:0]  div_a,
    output logic [DIV_W-1:0]  div_b,
    output logic [WARB_W-1:0] warble,
    output wr_ctrl_t          ctrl
);
    typedef struct packed {
        logic [DIV_W-1:0]  a;
        logic [DIV_W-1:0]  b;
        logic [WARB_W-1:0] w;
        wr_ctrl_t          c;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (wr_addr)
                ADDR_TONE_A: st_d.a = wr_data[DIV_W-1:0];
                ADDR_TONE_B: st_d.b = wr_data[DIV_W-1:0];
                ADDR_WARBLE: st_d.w = wr_data[WARB_W-1:0];
                ADDR_CTRL:   st_d.c = wr_ctrl_t'(wr_data[CTRL_W-1:0]);
                default:     st_d   = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign div_a  = st_q.a;
    assign div_b  = st_q.b;
    assign warble = st_q.w;
    assign ctrl   = st_q.c;
endmodule

// File: rtl/wr_warble.sv
module wr_warble #(
    parameter int WARB_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [WARB_W-1:0] period,
    output logic              sel
);
    typedef struct packed {
        logic [WARB_W-1:0] cnt;
        logic              sel;
    } warb_t;

    warb_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en) begin
            st_d = '0;
        end else if (period != '0) begin
            if (st_q.cnt >= period - 1'b1) begin
                st_d.cnt = '0;
                st_d.sel = ~st_q.sel;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sel = st_q.sel;
endmodule

// File: rtl/wr_half_cnt.sv
module wr_half_cnt #(
    parameter int DIV_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             sel,
    input  logic [DIV_W-1:0] div_a,
    input  logic [DIV_W-1:0] div_b,
    output logic             sq
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             sq;
    } half_t;

    half_t            st_d, st_q;
    logic [DIV_W-1:0] cur_div;
    logic [DIV_W-1:0] reload;

    always_comb begin
        cur_div = sel ? div_b : div_a;
        reload  = (cur_div == '0) ? '0 : cur_div - 1'b1;
        st_d    = st_q;
        if (!en) begin
            st_d = '0;
        end else if (st_q.cnt == '0) begin
            st_d.sq  = ~st_q.sq;
            st_d.cnt = reload;
        end else begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sq = st_q.sq;
endmodule

// File: rtl/warble_ringer.sv
module warble_ringer
    import wr_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DIV_W  = 12,
    parameter int WARB_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              ring_sq,
    output logic              path_ringer,
    output logic              gain_en,
    output logic [1:0]        atten_code
);
    logic [DIV_W-1:0]  div_a, div_b;
    logic [WARB_W-1:0] warble;
    wr_ctrl_t          ctrl;
    logic              tone_sel;
    logic              tone_sq;

    wr_regs #(.DATA_W(DATA_W), .DIV_W(DIV_W), .WARB_W(WARB_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .div_a(div_a), .div_b(div_b),
        .warble(warble), .ctrl(ctrl)
    );

    wr_warble #(.WARB_W(WARB_W)) u_warb (
        .clk(clk), .rst_n(rst_n), .en(ctrl.enable),
        .period(warble), .sel(tone_sel)
    );

    wr_half_cnt #(.DIV_W(DIV_W)) u_tone (
        .clk(clk), .rst_n(rst_n), .en(ctrl.enable), .sel(tone_sel),
        .div_a(div_a), .div_b(div_b), .sq(tone_sq)
    );

    assign ring_sq     = tone_sq & ctrl.to_ringer;
    assign path_ringer = ctrl.to_ringer;
    assign gain_en     = ctrl.enable;
    assign atten_code  = ctrl.atten;
endmodule

// File: rtl/wr_checker.sv
module wr_checker #(
    parameter int DIV_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [2:0]       wr_addr,
    input logic [1:0]       atten_wr,
    input logic             en,
    input logic             tone_sq,
    input logic [DIV_W-1:0] tone_cnt,
    input logic             ring_sq,
    input logic             path_ringer,
    input logic             gain_en,
    input logic [1:0]       atten_code
);
    p_silent_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !ring_sq);

    p_hold_mid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tone_cnt != '0) |=> $stable(tone_sq));

    p_atten_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 3'd3) |=> atten_code == $past(atten_wr));

    p_route_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ring_sq) |-> path_ringer);

    p_ignore_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[2]) |=>
            ($stable(atten_code) && $stable(path_ringer) && $stable(gain_en)));
endmodule

bind warble_ringer wr_checker #(.DIV_W(DIV_W)) u_wr_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .atten_wr(wr_data[3:2]), .en(ctrl.enable), .tone_sq(tone_sq),
    .tone_cnt(u_tone.st_q.cnt), .ring_sq(ring_sq),
    .path_ringer(path_ringer), .gain_en(gain_en), .atten_code(atten_code)
);

// File: tb/warble_ringer_tb_top.sv
module warble_ringer_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DATA_W = 16;
    localparam int DIV_W  = 12;
    localparam int WARB_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [2:0]        wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              ring_sq, path_ringer, gain_en;
    logic [1:0]        atten_code;

    int    n_checks = 0;
    int    n_fail   = 0;
    int    cycles   = 0;
    bit    track    = 1'b0;
    string cur_req  = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    warble_ringer #(.DATA_W(DATA_W), .DIV_W(DIV_W), .WARB_W(WARB_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ring_sq(ring_sq), .path_ringer(path_ringer),
        .gain_en(gain_en), .atten_code(atten_code)
    );

    // reference model of the requirements, stepped once per clock
    logic [DIV_W-1:0]  m_a, m_b, m_cnt;
    logic [WARB_W-1:0] m_w, m_wc;
    logic [3:0]        m_ctl;
    logic              m_sq, m_sel;

    function automatic logic [DIV_W-1:0] half_reload(input logic [DIV_W-1:0] d);
        return (d == '0) ? '0 : d - 1'b1;
    endfunction

    function automatic logic [4:0] expected_outs();
        return {m_sq & m_ctl[0], m_ctl[0], m_ctl[1], m_ctl[3:2]};
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_a <= '0; m_b <= '0; m_w <= '0; m_ctl <= '0;
            m_cnt <= '0; m_wc <= '0; m_sq <= 1'b0; m_sel <= 1'b0;
        end else begin
            if (wr_en) begin
                case (wr_addr)
                    3'd0: m_a   <= wr_data[DIV_W-1:0];
                    3'd1: m_b   <= wr_data[DIV_W-1:0];
                    3'd2: m_w   <= wr_data[WARB_W-1:0];
                    3'd3: m_ctl <= wr_data[3:0];
                    default: ;
                endcase
            end
            if (!m_ctl[1]) begin
                m_cnt <= '0; m_wc <= '0; m_sq <= 1'b0; m_sel <= 1'b0;
            end else begin
                if (m_cnt == '0) begin
                    m_sq  <= ~m_sq;
                    m_cnt <= half_reload(m_sel ? m_b : m_a);
                end else begin
                    m_cnt <= m_cnt - 1'b1;
                end
                if (m_w != '0) begin
                    if (m_wc >= m_w - 1'b1) begin
                        m_wc <= '0; m_sel <= ~m_sel;
                    end else begin
                        m_wc <= m_wc + 1'b1;
                    end
                end
            end
        end
    end

    task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {ring,path,gain,atten} actual=%b expected=%b at cycle %0d",
                     req, act, exp, cycles);
        end
    endtask

    function automatic logic [4:0] outs();
        return {ring_sq, path_ringer, gain_en, atten_code};
    endfunction

    // per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (rst_n && track) check(cur_req, outs(), expected_outs());
    end

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        while (cycles < 150000) @(negedge clk);
        n_fail++;
        $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
        finish_run();
    end

    initial begin
        void'($urandom(32'd4242));
        // R1: reset state
        idle(3);
        check("R1", outs(), 5'b0);
        rst_n = 1'b1;
        idle(2);
        check("R1", outs(), 5'b0);
        track = 1'b1;

        // R3: start-up timing with divisor 3, no warble
        cur_req = "R3";
        wr(3'd0, 16'd3);
        wr(3'd1, 16'd5);
        wr(3'd3, 16'b0111);
        check("R3", {ring_sq, 4'b0}, 5'b0);
        idle(1); check("R3", {ring_sq, 4'b0}, 5'b10000);
        idle(2); check("R3", {ring_sq, 4'b0}, 5'b10000);
        idle(1); check("R3", {ring_sq, 4'b0}, 5'b00000);
        idle(3); check("R3", {ring_sq, 4'b0}, 5'b10000);
        idle(30);

        // R4: warble between A and B
        cur_req = "R4";
        wr(3'd2, 16'd17);
        idle(120);
        wr(3'd2, 16'd0);
        idle(40);

        // R5: divisor rewritten mid half-period
        cur_req = "R5";
        wr(3'd2, 16'd23);
        idle(4);
        wr(3'd0, 16'd7);
        idle(2);
        wr(3'd1, 16'd2);
        idle(80);

        // R7: routing to codec path keeps ringer output low
        cur_req = "R7";
        wr(3'd3, 16'b0110);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            check("R7", {ring_sq, path_ringer, 3'b0}, 5'b0);
        end
        wr(3'd3, 16'b0111);
        idle(20);

        // R6: disable then restart on tone A
        cur_req = "R6";
        wr(3'd3, 16'b0101);
        idle(1);
        check("R6", {ring_sq, 4'b0}, 5'b0);
        idle(10);
        wr(3'd3, 16'b0111);
        check("R6", {ring_sq, 4'b0}, 5'b0);
        idle(1);
        check("R6", {ring_sq, 4'b0}, 5'b10000);
        idle(40);

        // R8: all four attenuation codes
        cur_req = "R8";
        for (int g = 0; g < 4; g++) begin
            wr(3'd3, 16'(g << 2) | 16'b0011);
            check("R8", {2'b0, gain_en, atten_code}, {2'b0, 1'b1, 2'(g)});
        end
        wr(3'd3, 16'b1001);
        check("R8", {2'b0, gain_en, atten_code}, 5'b00010);

        // R9: unused addresses
        cur_req = "R9";
        wr(3'd3, 16'b0111);
        idle(5);
        for (int a = 4; a < 8; a++) begin
            wr(3'(a), 16'hFFFF);
            check("R9", {1'b0, path_ringer, gain_en, atten_code}, 5'b01101);
        end
        idle(20);

        // R3: zero divisor acts as one
        cur_req = "R3";
        wr(3'd2, 16'd0);
        wr(3'd0, 16'd0);
        wr(3'd3, 16'b0001);
        wr(3'd3, 16'b0011);
        idle(1); check("R3", {ring_sq, 4'b0}, 5'b10000);
        idle(1); check("R3", {ring_sq, 4'b0}, 5'b00000);
        idle(1); check("R3", {ring_sq, 4'b0}, 5'b10000);

        // R2: random register traffic against the model
        cur_req = "R2";
        for (int i = 0; i < 500; i++) begin
            logic [2:0]  a;
            logic [15:0] d;
            a = 3'($urandom_range(0, 7));
            case (a)
                3'd0, 3'd1: d = 16'($urandom_range(0, 12));
                3'd2:       d = 16'($urandom_range(0, 30));
                3'd3:       d = ($urandom_range(0, 9) < 8) ? (16'($urandom_range(0, 15)) | 16'b0010)
                                                            : 16'($urandom_range(0, 15));
                default:    d = 16'($urandom);
            endcase
            wr(a, d);
            idle($urandom_range(0, 18));
        end

        track = 1'b0;
        finish_run();
    end
endmodule